// File: doc/BRIEF.md
# Joystick SPI transaction controller

This block is an SPI bus master that runs one fixed exchange with a joystick peripheral. A single-cycle start request makes it capture a two-bit lamp request and drive the active-low select line low. After a long setup pause it clocks five bytes in each direction. The first byte out is a command that carries the lamp bits; the four bytes that follow are zeros. The five bytes coming back hold two 10-bit axis positions, each split into a low byte and a high byte, and a byte of button flags.

The serial clock comes from a free-running divider of the system clock and is gated by the controller. The bus runs with the clock idling low; the data line out changes on the rising edge and the data line in is sampled on the falling edge. A pause of at least the inter-byte interval separates consecutive bytes. Once the last bit has been sampled, the controller releases select, loads the decoded X, Y and button registers and pulses done for one cycle. The output registers change at no other time.

Top module: `joy_spi_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, ss_n_o is 1, sck_o is 0, mosi_o is 0, busy_o and done_o are 0, and x_o, y_o and btn_o are 0.
- R2: A start_i seen while idle drives ss_n_o low and busy_o high on the next cycle. A start_i seen while busy_o is 1 has no effect: select falls only once and the command byte keeps the first lamp value.
- R3: At least SETUP_CYC system cycles (default 1500) pass between the fall of ss_n_o and the first rising edge of sck_o.
- R4: sck_o is low whenever ss_n_o is high. Within a byte, consecutive rising edges are DIV_RATIO cycles apart (default 128). Each exchange has exactly 40 falling edges.
- R5: mosi_o changes only in the cycle in which sck_o rises. miso_i is sampled when sck_o falls.
- R6: The first byte on mosi_o, sent MSB first, is {1, 0, 0, 0, 0, 0, L[1], L[0]}, where L is led_i as seen in the start cycle. Later changes to led_i have no effect on it.
- R7: Bytes 2 to 5 on mosi_o are all zero.
- R8: At least GAP_CYC system cycles (default 1000) pass between the last falling sck_o edge of one byte and the first rising edge of the next byte.
- R9: The 40 received bits, taken MSB first, form frame F with the first byte in F[39:32]. x_o = {F[25:24], F[39:32]}, y_o = {F[9:8], F[23:16]} and btn_o = F[2:0].
- R10: x_o, y_o and btn_o change only in the cycle in which done_o is 1. done_o is high for exactly one cycle, in the same cycle that ss_n_o returns high and busy_o falls.
- R11: A reset during an exchange stops it at once: select high, sck_o low, busy_o low, outputs cleared. The next start runs a complete, correct exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one exchange; acted on only when idle |
| led_i | input | 2 | Lamp request placed in the command byte |
| miso_i | input | 1 | Serial data from the peripheral |
| ss_n_o | output | 1 | Active-low slave select |
| sck_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the peripheral |
| x_o | output | 10 | Decoded X position |
| y_o | output | 10 | Decoded Y position |
| btn_o | output | 3 | Decoded button flags |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle pulse when results load |

## Verification
Select and busy respond one cycle after start_i is sampled, so the bench checks them at the first falling clock edge after its start pulse. Decoded results, select release and done all become visible at the same edge, one cycle after the 40th falling sck_o edge. The bench polls for done_o at falling clock edges and reads every result in that same sample. The single-cycle nature of done is checked one sample later. A bus monitor takes timestamps at falling system-clock edges, so each measured setup pause, inter-byte gap and clock period is a whole count of system cycles, and these counts are compared against the lower bounds.

// File: rtl/joy_spi_pkg.sv
package joy_spi_pkg;

    localparam int JOY_BYTE_BITS   = 8;
    localparam int JOY_FRAME_BYTES = 5;
    localparam int JOY_FRAME_BITS  = JOY_BYTE_BITS * JOY_FRAME_BYTES;
    localparam int JOY_AXIS_BITS   = 10;
    localparam int JOY_KEY_BITS    = 3;
    localparam int JOY_LAMP_BITS   = 2;

    typedef logic [JOY_BYTE_BITS-1:0]  byte_t;
    typedef logic [JOY_FRAME_BITS-1:0] frame_t;
    typedef logic [JOY_LAMP_BITS-1:0]  lamp_t;

    typedef struct packed {
        logic [JOY_AXIS_BITS-1:0] x;
        logic [JOY_AXIS_BITS-1:0] y;
        logic [JOY_KEY_BITS-1:0]  keys;
    } joy_sample_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ALIGN_HI,
        ST_ALIGN_LO,
        ST_SHIFT,
        ST_GAP,
        ST_COMMIT
    } xfer_state_t;

    // Command byte: marker bit on top, five zeros, lamp bit 1 then lamp bit 0.
    function automatic byte_t make_command(input lamp_t lamp);
        return {1'b1, 5'b00000, lamp[1], lamp[0]};
    endfunction

    // Axis low bytes arrive first; only two bits of each high byte are used.
    function automatic joy_sample_t unpack_frame(input frame_t f);
        joy_sample_t s;
        s.x    = {f[25:24], f[39:32]};
        s.y    = {f[9:8],   f[23:16]};
        s.keys = f[2:0];
        return s;
    endfunction

endpackage

// File: rtl/joy_sck_div.sv
module joy_sck_div #(
    parameter int unsigned DIV_RATIO = 128
) (
    input  logic clk,
    input  logic rst,
    output logic phase_hi_o,
    output logic rise_ev_o,
    output logic fall_ev_o
);
    localparam int unsigned HALF = DIV_RATIO / 2;
    localparam int unsigned CW   = $clog2(DIV_RATIO);
    localparam logic [CW-1:0] LAST_CNT = CW'(DIV_RATIO - 1);
    localparam logic [CW-1:0] RISE_CNT = CW'(HALF - 1);
    localparam logic [CW-1:0] HI_CNT   = CW'(HALF);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST_CNT) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase_hi_o = (cnt_q >= HI_CNT);
    assign rise_ev_o  = (cnt_q == RISE_CNT);
    assign fall_ev_o  = (cnt_q == LAST_CNT);

endmodule

// File: rtl/joy_interval_timer.sv
module joy_interval_timer #(
    parameter int unsigned SPAN = 1500
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned TW = $clog2(SPAN + 1);
    localparam logic [TW-1:0] SPAN_V = TW'(SPAN);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= SPAN_V;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign expired_o = (left_q == '0);

endmodule

// File: rtl/joy_shift_path.sv
module joy_shift_path
    import joy_spi_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_i,
    input  byte_t  cmd_i,
    input  logic   tx_step_i,
    input  logic   rx_step_i,
    input  logic   miso_i,
    output logic   mosi_o,
    output frame_t frame_o
);
    byte_t  tx_q;
    frame_t rx_q;
    logic   mosi_q;

    // Outgoing path: the MSB leaves first and zeros fill in behind it,
    // so every byte after the command goes out as zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            mosi_q <= 1'b0;
        end else if (load_i) begin
            tx_q   <= cmd_i;
        end else if (tx_step_i) begin
            mosi_q <= tx_q[JOY_BYTE_BITS-1];
            tx_q   <= {tx_q[JOY_BYTE_BITS-2:0], 1'b0};
        end
    end

    // Incoming path: shift left so the first bit ends at the top.
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
        end else if (rx_step_i) begin
            rx_q <= {rx_q[JOY_FRAME_BITS-2:0], miso_i};
        end
    end

    assign mosi_o  = mosi_q;
    assign frame_o = rx_q;

endmodule

// File: rtl/joy_spi_ctrl.sv
module joy_spi_ctrl
    import joy_spi_pkg::*;
#(
    parameter int unsigned DIV_RATIO = 128,
    parameter int unsigned SETUP_CYC = 1500,
    parameter int unsigned GAP_CYC   = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [1:0] led_i,
    input  logic       miso_i,
    output logic       ss_n_o,
    output logic       sck_o,
    output logic       mosi_o,
    output logic [9:0] x_o,
    output logic [9:0] y_o,
    output logic [2:0] btn_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam int unsigned BIT_W  = $clog2(JOY_BYTE_BITS);
    localparam int unsigned BYTE_W = $clog2(JOY_FRAME_BYTES);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(JOY_BYTE_BITS - 1);
    localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(JOY_FRAME_BYTES - 1);

    xfer_state_t state_q, state_d;

    logic phase_hi, rise_ev, fall_ev;
    logic setup_load, setup_expired;
    logic gap_load, gap_expired;
    logic tx_load, tx_step, rx_step;
    logic frame_end, byte_end;

    logic [BIT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] byte_q;
    logic              ss_n_q;
    logic              sck_q;
    logic              done_q;
    joy_sample_t       sample_q;
    frame_t            frame;

    joy_sck_div #(.DIV_RATIO(DIV_RATIO)) div_i (
        .clk        (clk),
        .rst        (rst),
        .phase_hi_o (phase_hi),
        .rise_ev_o  (rise_ev),
        .fall_ev_o  (fall_ev)
    );

    joy_interval_timer #(.SPAN(SETUP_CYC)) setup_tmr_i (
        .clk       (clk),
        .rst       (rst),
        .load_i    (setup_load),
        .expired_o (setup_expired)
    );

    joy_interval_timer #(.SPAN(GAP_CYC)) gap_tmr_i (
        .clk       (clk),
        .rst       (rst),
        .load_i    (gap_load),
        .expired_o (gap_expired)
    );

    joy_shift_path path_i (
        .clk       (clk),
        .rst       (rst),
        .load_i    (tx_load),
        .cmd_i     (make_command(led_i)),
        .tx_step_i (tx_step),
        .rx_step_i (rx_step),
        .miso_i    (miso_i),
        .mosi_o    (mosi_o),
        .frame_o   (frame)
    );

    assign byte_end  = fall_ev && (bit_q == LAST_BIT);
    assign frame_end = byte_end && (byte_q == LAST_BYTE);

    always_comb begin
        state_d    = state_q;
        tx_load    = 1'b0;
        tx_step    = 1'b0;
        rx_step    = 1'b0;
        setup_load = 1'b0;
        gap_load   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    tx_load    = 1'b1;
                    setup_load = 1'b1;
                    state_d    = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (setup_expired) state_d = ST_ALIGN_HI;
            end
            ST_ALIGN_HI: begin
                if (phase_hi) state_d = ST_ALIGN_LO;
            end
            ST_ALIGN_LO: begin
                if (!phase_hi) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                tx_step = rise_ev;
                rx_step = fall_ev;
                if (frame_end) begin
                    state_d = ST_COMMIT;
                end else if (byte_end) begin
                    gap_load = 1'b1;
                    state_d  = ST_GAP;
                end
            end
            ST_GAP: begin
                if (gap_expired) state_d = ST_ALIGN_HI;
            end
            ST_COMMIT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Bit and byte counters
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q  <= '0;
            byte_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                byte_q <= '0;
            end else if (byte_end && state_q == ST_SHIFT) begin
                byte_q <= byte_q + 1'b1;
            end
            if (state_q == ST_ALIGN_LO && !phase_hi) begin
                bit_q <= '0;
            end else if (rx_step) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Bus pins: select and serial clock are held in flops
    always_ff @(posedge clk) begin
        if (rst) begin
            ss_n_q <= 1'b1;
            sck_q  <= 1'b0;
        end else begin
            ss_n_q <= (state_d == ST_IDLE);
            if (state_q == ST_SHIFT && rise_ev) begin
                sck_q <= 1'b1;
            end else if (fall_ev) begin
                sck_q <= 1'b0;
            end
        end
    end

    // Result registers load once per frame
    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state_q == ST_COMMIT);
            if (state_q == ST_COMMIT) begin
                sample_q <= unpack_frame(frame);
            end
        end
    end

    assign ss_n_o = ss_n_q;
    assign sck_o  = sck_q;
    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign x_o    = sample_q.x;
    assign y_o    = sample_q.y;
    assign btn_o  = sample_q.keys;

endmodule

// File: rtl/joy_spi_ctrl_chk.sv
module joy_spi_ctrl_chk #(
    parameter int unsigned SETUP_CYC = 1500,
    parameter int unsigned GAP_CYC   = 1000
) (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       ss_n_o,
    input logic       sck_o,
    input logic       mosi_o,
    input logic [9:0] x_o,
    input logic [9:0] y_o,
    input logic [2:0] btn_o,
    input logic       busy_o,
    input logic       done_o
);
    localparam int unsigned SAT = 1 << 20;

    logic        sck_d;
    int unsigned since_sel;
    int unsigned since_fall;
    int unsigned fall_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d      <= 1'b0;
            since_sel  <= 0;
            since_fall <= 0;
            fall_n     <= 0;
        end else begin
            sck_d <= sck_o;
            if (ss_n_o) begin
                since_sel  <= 0;
                since_fall <= 0;
                fall_n     <= 0;
            end else begin
                if (since_sel < SAT) since_sel <= since_sel + 1;
                if (sck_d && !sck_o) begin
                    fall_n     <= fall_n + 1;
                    since_fall <= 0;
                end else if (since_fall < SAT) begin
                    since_fall <= since_fall + 1;
                end
            end
        end
    end

    // R1
    idle_select_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> ss_n_o);

    // R2
    start_selects_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (!ss_n_o && busy_o));

    // R3
    setup_pause_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sck_o) && fall_n == 0) |-> (since_sel >= SETUP_CYC));

    // R4
    sck_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
        sck_o |-> !ss_n_o);

    // R5
    mosi_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mosi_o) |-> $rose(sck_o));

    // R8
    byte_pause_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sck_o) && fall_n != 0 && (fall_n % 8) == 0) |-> (since_fall >= GAP_CYC));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10
    done_with_release_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (ss_n_o && $past(!ss_n_o) && !busy_o));

    // R10
    results_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(x_o) && $stable(y_o) && $stable(btn_o)));

endmodule

bind joy_spi_ctrl joy_spi_ctrl_chk #(
    .SETUP_CYC(SETUP_CYC),
    .GAP_CYC  (GAP_CYC)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .ss_n_o  (ss_n_o),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .x_o     (x_o),
    .y_o     (y_o),
    .btn_o   (btn_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/joy_spi_ctrl_tb_top.sv
`timescale 1ns/1ps
module joy_spi_ctrl_tb_top;

    localparam int DIV   = 128;
    localparam int SETUP = 1500;
    localparam int GAP   = 1000;
    localparam int NVEC  = 4;
    localparam int LIMIT = 20000;

    // {lamp[1:0], peripheral reply frame[39:0]}
    localparam logic [41:0] VEC [NVEC] = '{
        {2'b01, 40'h3A_01_C4_02_05},
        {2'b10, 40'hFF_03_00_00_02},
        {2'b11, 40'h00_FC_FF_FE_F8},
        {2'b00, 40'h55_AA_AA_55_07}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] led = 2'b00;
    logic       miso = 1'b0;
    logic       ss_n, sck, mosi, busy, done;
    logic [9:0] x, y;
    logic [2:0] btn;

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    joy_spi_ctrl #(.DIV_RATIO(DIV), .SETUP_CYC(SETUP), .GAP_CYC(GAP)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .led_i(led), .miso_i(miso),
        .ss_n_o(ss_n), .sck_o(sck), .mosi_o(mosi), .x_o(x), .y_o(y),
        .btn_o(btn), .busy_o(busy), .done_o(done)
    );

    // Bus monitor and peripheral model, sampled at falling system edges
    int          cyc = 0;
    int          t_sel = 0, t_fall = 0, t_rise = 0;
    int          rises = 0, falls = 0, setup_seen = 0, min_gap = 0, sel_count = 0;
    bit          period_ok = 1'b1;
    logic [39:0] mosi_cap = '0;
    logic [39:0] slave_frame = '0;
    logic        sck_prev = 1'b0, ss_prev = 1'b1;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (ss_prev === 1'b1 && ss_n === 1'b0) begin
            t_sel     = cyc;
            rises     = 0;
            falls     = 0;
            min_gap   = 1 << 30;
            period_ok = 1'b1;
            sel_count = sel_count + 1;
        end
        if (sck_prev === 1'b0 && sck === 1'b1) begin
            if (rises == 0) begin
                setup_seen = cyc - t_sel;
            end else if (rises % 8 == 0) begin
                if (cyc - t_fall < min_gap) min_gap = cyc - t_fall;
            end else if (cyc - t_rise != DIV) begin
                period_ok = 1'b0;
            end
            // peripheral shifts its next bit out on the rising edge
            if (rises < 40) miso = slave_frame[39 - rises];
            t_rise = cyc;
            rises  = rises + 1;
        end
        if (sck_prev === 1'b1 && sck === 1'b0) begin
            t_fall   = cyc;
            falls    = falls + 1;
            mosi_cap = {mosi_cap[38:0], mosi};
        end
        sck_prev = sck;
        ss_prev  = ss_n;
    end

    task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input int act, input int lo);
        compared++;
        if (act < lo) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected >= %0d", req, act, lo);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        int n = 0;
        while (done !== 1'b1 && n < LIMIT) begin
            @(negedge clk);
            n++;
        end
        seen = (done === 1'b1);
    endtask

    task automatic run_vec(input int v, input logic [9:0] px, input logic [9:0] py, input logic [2:0] pb);
        logic [1:0]  lamp;
        logic [39:0] resp;
        logic [7:0]  cmd;
        bit          seen;
        lamp = VEC[v][41:40];
        resp = VEC[v][39:0];
        cmd  = {1'b1, 5'b00000, lamp[1], lamp[0]};
        slave_frame = resp;
        led = lamp;
        pulse_start();
        check_eq("R2 select low after start", {63'd0, ss_n}, 64'd0);
        check_eq("R2 busy after start", {63'd0, busy}, 64'd1);
        led = ~lamp;  // R6: must not reach the command byte
        repeat (3000) @(negedge clk);
        // R10: no partial frame visible mid-exchange
        check_eq("R10 x held mid-exchange", {54'd0, x}, {54'd0, px});
        check_eq("R10 y held mid-exchange", {54'd0, y}, {54'd0, py});
        check_eq("R10 btn held mid-exchange", {61'd0, btn}, {61'd0, pb});
        wait_done(seen);
        check_eq("R10 done reached", {63'd0, seen}, 64'd1);
        check_eq("R9 x decode", {54'd0, x}, {54'd0, resp[25:24], resp[39:32]});
        check_eq("R9 y decode", {54'd0, y}, {54'd0, resp[9:8], resp[23:16]});
        check_eq("R9 btn decode", {61'd0, btn}, {61'd0, resp[2:0]});
        check_eq("R10 select released with done", {63'd0, ss_n}, 64'd1);
        check_eq("R6 command byte", {56'd0, mosi_cap[39:32]}, {56'd0, cmd});
        check_eq("R7 trailing bytes zero", {32'd0, mosi_cap[31:0]}, 64'd0);
        check_eq("R4 falling edges per exchange", 64'(falls), 64'd40);
        check_eq("R4 sck period within byte", {63'd0, period_ok}, 64'd1);
        check_ge("R3 setup pause", setup_seen, SETUP);
        check_ge("R8 inter-byte pause", min_gap, GAP);
        @(negedge clk);
        check_eq("R10 done one cycle", {63'd0, done}, 64'd0);
        check_eq("R10 busy clear", {63'd0, busy}, 64'd0);
    endtask

    initial begin
        logic [9:0] px, py;
        logic [2:0] pb;
        bit         seen;
        int         sel_before;

        repeat (4) @(negedge clk);
        // R1 during reset
        check_eq("R1 select in reset", {63'd0, ss_n}, 64'd1);
        check_eq("R1 sck in reset", {63'd0, sck}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 select idle", {63'd0, ss_n}, 64'd1);
        check_eq("R1 sck idle", {63'd0, sck}, 64'd0);
        check_eq("R1 mosi idle", {63'd0, mosi}, 64'd0);
        check_eq("R1 busy idle", {63'd0, busy}, 64'd0);
        check_eq("R1 done idle", {63'd0, done}, 64'd0);
        check_eq("R1 outputs cleared", {41'd0, x, y, btn}, 64'd0);

        px = '0; py = '0; pb = '0;
        for (int v = 0; v < NVEC; v++) begin
            run_vec(v, px, py, pb);
            px = x; py = y; pb = btn;
        end

        // R2: start requests during an exchange are ignored
        sel_before = sel_count;
        slave_frame = 40'h12_01_34_02_06;
        led = 2'b01;
        pulse_start();
        repeat (2000) @(negedge clk);
        led = 2'b10;
        pulse_start();
        repeat (4000) @(negedge clk);
        pulse_start();
        wait_done(seen);
        check_eq("R2 exchange completes", {63'd0, seen}, 64'd1);
        check_eq("R2 single select fall", 64'(sel_count - sel_before), 64'd1);
        check_eq("R2 first lamp kept", {56'd0, mosi_cap[39:32]}, 64'h81);
        check_eq("R2 no extra bits", 64'(falls), 64'd40);
        repeat (200) @(negedge clk);
        check_eq("R2 stays idle after", {63'd0, busy}, 64'd0);

        // R11: reset in the middle of an exchange
        slave_frame = 40'hAB_02_CD_01_03;
        led = 2'b11;
        pulse_start();
        repeat (4000) @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R11 select after abort", {63'd0, ss_n}, 64'd1);
        check_eq("R11 sck after abort", {63'd0, sck}, 64'd0);
        check_eq("R11 busy after abort", {63'd0, busy}, 64'd0);
        check_eq("R11 outputs cleared", {41'd0, x, y, btn}, 64'd0);
        run_vec(0, 10'd0, 10'd0, 3'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog R10: actual timeout expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule